// File: doc/BRIEF.md
# Hot-Swap Fault and Retry Sequencer

This block is the digital sequencer of a hot-swap power switch. It receives comparator results that have already been sampled into the clock domain: a current-sense-over-threshold flag, input undervoltage and overvoltage flags, a fixed supply-overvoltage flag, a card-present enable, an on request, a power-good flag and a cool-down timer flag. From these it drives the enable for the external pass-device gate driver, sticky fault status bits, a routed power status pin and an active-low alert.

An overcurrent condition trips the breaker only after it has held without a break for a filter window. The filter window is 20 µs by default, or 420 µs when the long-filter build is chosen, and it is converted to clock cycles from the clock frequency. After a trip the gate is switched off and the block waits out a cool-down period. That period ends either when the external timer comparator reports that it is below threshold, or after an internal count of 5 s. The sequencer then either restarts on its own or stays latched off, as a control bit selects. A supply overvoltage removes the gate enable combinationally in the same cycle.

A small register-write port configures the block. Address 0 is the control word. A write to address 1 clears fault bits: each 1 in the written data clears the matching bit.

Top module: `hsw_seq`

## Requirements
- R1: While `por_n` is low, `gate_o` is 0, `fault_o` is 0, `alert_n_o` is 1 and the control word is all zero.
- R2: The gate turns on only when `en_i` is 1, `uv_bad_i` is 0, `ov_bad_i` is 0, `vdd_ov_i` is 0 and the on condition is true. If control bit 3 (auto-on) is 1, the on condition is `on_i`. If that bit is 0, the on condition is control bit 0 (host on). The gate rises one clock edge after these conditions hold, and it falls at the next edge after any of them is lost.
- R3: A breaker trip happens only after `oc_i` has been sampled high on CB consecutive edges while the gate is on. CB is ceil(CLK_KHZ × 20 / 1000) cycles, or ceil(CLK_KHZ × 420 / 1000) cycles when LONG_CB = 1. A gap in `oc_i` restarts the count.
- R4: On the trip edge the gate turns off and fault bit 0 (overcurrent) is set.
- R5: `vdd_ov_i` forces `gate_o` low in the same cycle. At the next edge fault bit 1 (overvoltage) is set and the sequencer returns to off.
- R6: If control bit 2 (internal cool-down) is 0, the cool-down ends at the first edge at which `tmr_low_i` is sampled high.
- R7: If control bit 2 is 1, the cool-down ends at the edge that comes COOL = CLK_KHZ × COOL_MS edges after the trip edge. `tmr_low_i` is ignored in this mode.
- R8: If control bit 1 (auto-retry) is 1, the gate turns on again one edge after the cool-down ends, provided the R2 conditions hold.
- R9: If control bit 1 is 0, the gate stays off after the cool-down. It leaves this state when fault bit 0 is cleared, or when the on condition rises from 0 to 1. The gate then turns on after two further edges.
- R10: Fault bits stay set until a write to address 1 with a 1 in the matching data bit. A set event in the same cycle takes priority over the clear.
- R11: `alert_n_o` is 0 exactly when control bit 4 (alert enable) is 1 and at least one fault bit is set.
- R12: Control bits 6:5 route the power status to `stat_o`: 01 gives `pg_i`, 10 gives the inverse of `pg_i`, and any other value gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Active-low power-up initialisation |
| oc_i | input | 1 | Sense voltage above breaker threshold |
| uv_bad_i | input | 1 | Input below undervoltage threshold |
| ov_bad_i | input | 1 | Input above overvoltage threshold |
| vdd_ov_i | input | 1 | Fixed supply-overvoltage comparator |
| en_i | input | 1 | Card present |
| on_i | input | 1 | On request pin |
| pg_i | input | 1 | Output power good |
| tmr_low_i | input | 1 | External timer below cool-down threshold |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address (0 control, 1 fault clear) |
| wr_data_i | input | 8 | Register write data |
| gate_o | output | 1 | Gate driver enable |
| fault_o | output | 2 | Sticky faults: bit 0 overcurrent, bit 1 overvoltage |
| stat_o | output | 1 | Routed power status |
| alert_n_o | output | 1 | Active-low alert |

## Verification
The bench builds the block with CLK_KHZ = 200, COOL_MS = 1 and LONG_CB = 0. This makes the breaker window 4 cycles and the internal cool-down 200 cycles. With windows this short, the bench can sweep every overcurrent pulse length up to the trip point and watch every cool-down to the exact edge. It also runs all sixteen combinations of the four start conditions. The defaults (5 s at 1 MHz) only set counter widths and leave the logic unchanged.

// File: rtl/hsw_pkg.sv
package hsw_pkg;
  typedef enum logic [1:0] {ST_OFF, ST_ON, ST_COOL, ST_HOLD} hsw_state_e;

  // control word, bit 0 at the bottom
  typedef struct packed {
    logic [1:0] pg_mode;    // 6:5
    logic       alert_en;   // 4
    logic       auto_on;    // 3
    logic       int_cool;   // 2
    logic       auto_retry; // 1
    logic       host_on;    // 0
  } hsw_ctrl_t;

  localparam int FAULT_W = 2;
  localparam int FB_OC   = 0;
  localparam int FB_OV   = 1;

  function automatic int us_to_cycles(input int khz, input int us);
    return (khz * us + 999) / 1000;
  endfunction

  function automatic int ms_to_cycles(input int khz, input int ms);
    return khz * ms;
  endfunction

  function automatic logic route_status(input logic [1:0] mode, input logic pg);
    case (mode)
      2'b01:   return pg;
      2'b10:   return ~pg;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/hsw_cb_filter.sv
module hsw_cb_filter #(
  parameter int CYCLES = 20,
  localparam int W = $clog2(CYCLES + 1)
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic         arm,
  input  logic         oc,
  output logic         trip,
  output logic [W-1:0] cnt
);
  assign trip = arm & oc & (cnt == W'(CYCLES - 1));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                   cnt <= '0;
    else if (!arm || !oc || trip) cnt <= '0;
    else                          cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/hsw_cooldown.sv
module hsw_cooldown #(
  parameter int CYCLES = 5000000,
  localparam int W = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic por_n,
  input  logic active,
  input  logic use_int,
  input  logic tmr_low,
  output logic done
);
  logic [W-1:0] cnt;

  assign done = active & (use_int ? (cnt == W'(CYCLES - 1)) : tmr_low);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                 cnt <= '0;
    else if (!active || done)   cnt <= '0;
    else if (use_int)           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/hsw_regs.sv
module hsw_regs
  import hsw_pkg::*;
(
  input  logic               clk,
  input  logic               por_n,
  input  logic               wr_en,
  input  logic [1:0]         wr_addr,
  input  logic [7:0]         wr_data,
  input  logic [FAULT_W-1:0] set_fault,
  output hsw_ctrl_t          ctrl,
  output logic [FAULT_W-1:0] fault
);
  logic               ctrl_wr;
  logic [FAULT_W-1:0] clr;

  assign ctrl_wr = wr_en & (wr_addr == 2'd0);
  assign clr     = (wr_en && wr_addr == 2'd1) ? wr_data[FAULT_W-1:0] : '0;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      ctrl  <= '0;
      fault <= '0;
    end else begin
      if (ctrl_wr) ctrl <= hsw_ctrl_t'(wr_data[6:0]);
      fault <= (fault & ~clr) | set_fault;
    end
  end
endmodule

// File: rtl/hsw_seq.sv
module hsw_seq
  import hsw_pkg::*;
#(
  parameter int CLK_KHZ = 1000,
  parameter bit LONG_CB = 1'b0,
  parameter int COOL_MS = 5000,
  localparam int CB_CYCLES   = us_to_cycles(CLK_KHZ, LONG_CB ? 420 : 20),
  localparam int COOL_CYCLES = ms_to_cycles(CLK_KHZ, COOL_MS),
  localparam int CB_W        = $clog2(CB_CYCLES + 1)
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               oc_i,
  input  logic               uv_bad_i,
  input  logic               ov_bad_i,
  input  logic               vdd_ov_i,
  input  logic               en_i,
  input  logic               on_i,
  input  logic               pg_i,
  input  logic               tmr_low_i,
  input  logic               wr_en_i,
  input  logic [1:0]         wr_addr_i,
  input  logic [7:0]         wr_data_i,
  output logic               gate_o,
  output logic [FAULT_W-1:0] fault_o,
  output logic               stat_o,
  output logic               alert_n_o
);
  hsw_state_e         state, state_n;
  hsw_ctrl_t          ctrl;
  logic               on_cond, on_cond_q, on_rise, permit;
  logic               gate_q, cb_trip, cool_done;
  logic [CB_W-1:0]    cb_cnt;
  logic [FAULT_W-1:0] set_fault;

  assign on_cond = ctrl.auto_on ? on_i : ctrl.host_on;
  assign on_rise = on_cond & ~on_cond_q;
  assign permit  = en_i & on_cond & ~uv_bad_i & ~ov_bad_i & ~vdd_ov_i;
  assign gate_q  = (state == ST_ON);

  assign set_fault[FB_OC] = cb_trip;
  assign set_fault[FB_OV] = vdd_ov_i;

  hsw_regs u_regs (
    .clk(clk), .por_n(por_n), .wr_en(wr_en_i), .wr_addr(wr_addr_i),
    .wr_data(wr_data_i), .set_fault(set_fault), .ctrl(ctrl), .fault(fault_o)
  );

  hsw_cb_filter #(.CYCLES(CB_CYCLES)) u_cb (
    .clk(clk), .por_n(por_n), .arm(gate_q), .oc(oc_i),
    .trip(cb_trip), .cnt(cb_cnt)
  );

  hsw_cooldown #(.CYCLES(COOL_CYCLES)) u_cool (
    .clk(clk), .por_n(por_n), .active(state == ST_COOL),
    .use_int(ctrl.int_cool), .tmr_low(tmr_low_i), .done(cool_done)
  );

  always_comb begin
    state_n = state;
    case (state)
      ST_OFF:  if (permit) state_n = ST_ON;
      ST_ON: begin
        if (vdd_ov_i)     state_n = ST_OFF;
        else if (cb_trip) state_n = ST_COOL;
        else if (!permit) state_n = ST_OFF;
      end
      ST_COOL: if (cool_done) state_n = ctrl.auto_retry ? ST_OFF : ST_HOLD;
      ST_HOLD: if (!fault_o[FB_OC] || on_rise) state_n = ST_OFF;
      default: state_n = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state     <= ST_OFF;
      on_cond_q <= 1'b0;
    end else begin
      state     <= state_n;
      on_cond_q <= on_cond;
    end
  end

  assign gate_o    = gate_q & ~vdd_ov_i;
  assign stat_o    = route_status(ctrl.pg_mode, pg_i);
  assign alert_n_o = ~(ctrl.alert_en & (|fault_o));
endmodule

// File: rtl/hsw_seq_chk.sv
module hsw_seq_chk #(
  parameter int CB_CYCLES = 20,
  parameter int CB_W = 5
) (
  input logic            clk,
  input logic            por_n,
  input logic            en_i,
  input logic            uv_bad_i,
  input logic            ov_bad_i,
  input logic            vdd_ov_i,
  input logic            wr_en_i,
  input logic [1:0]      wr_addr_i,
  input logic [7:0]      wr_data_i,
  input logic            gate_q,
  input logic            cb_trip,
  input logic [CB_W-1:0] cb_cnt,
  input logic [1:0]      fault_o,
  input logic            alert_n_o
);
  p_gate_needs_permit_r2: assert property (@(posedge clk) disable iff (!por_n)
    $rose(gate_q) |-> $past(en_i && !uv_bad_i && !ov_bad_i && !vdd_ov_i));

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!por_n)
    cb_cnt < CB_W'(CB_CYCLES));

  p_trip_off_r4: assert property (@(posedge clk) disable iff (!por_n)
    cb_trip |=> (!gate_q && fault_o[0]));

  p_ov_fault_r5: assert property (@(posedge clk) disable iff (!por_n)
    vdd_ov_i |=> (fault_o[1] && !gate_q));

  p_sticky_r10: assert property (@(posedge clk) disable iff (!por_n)
    (fault_o[0] && !(wr_en_i && wr_addr_i == 2'd1 && wr_data_i[0])) |=> fault_o[0]);

  p_alert_r11: assert property (@(posedge clk) disable iff (!por_n)
    !alert_n_o |-> (fault_o != 2'b00));
endmodule

bind hsw_seq hsw_seq_chk #(.CB_CYCLES(CB_CYCLES), .CB_W(CB_W)) u_chk (
  .clk(clk), .por_n(por_n), .en_i(en_i), .uv_bad_i(uv_bad_i),
  .ov_bad_i(ov_bad_i), .vdd_ov_i(vdd_ov_i), .wr_en_i(wr_en_i),
  .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .gate_q(gate_q),
  .cb_trip(cb_trip), .cb_cnt(cb_cnt), .fault_o(fault_o), .alert_n_o(alert_n_o)
);

// File: tb/sim_hsw_seq.sv
module sim_hsw_seq;
  localparam int PERIOD = 10;
  localparam int KHZ    = 200;
  localparam int CMS    = 1;
  localparam int CB     = (KHZ * 20 + 999) / 1000;
  localparam int COOL   = KHZ * CMS;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic oc_i = 0, uv_bad_i = 0, ov_bad_i = 0, vdd_ov_i = 0, en_i = 0, on_i = 0;
  logic pg_i = 0, tmr_low_i = 0, wr_en_i = 0;
  logic [1:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic gate_o, stat_o, alert_n_o;
  logic [1:0] fault_o;
  int checks = 0, failures = 0;

  always #(PERIOD / 2) clk = ~clk;

  hsw_seq #(.CLK_KHZ(KHZ), .LONG_CB(1'b0), .COOL_MS(CMS)) u0 (
    .clk(clk), .por_n(por_n), .oc_i(oc_i), .uv_bad_i(uv_bad_i), .ov_bad_i(ov_bad_i),
    .vdd_ov_i(vdd_ov_i), .en_i(en_i), .on_i(on_i), .pg_i(pg_i), .tmr_low_i(tmr_low_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .gate_o(gate_o), .fault_o(fault_o), .stat_o(stat_o), .alert_n_o(alert_n_o)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    step(1);
    wr_en_i = 1'b0;
  endtask

  function automatic logic [7:0] cw(input logic [1:0] pg, input logic al, input logic ao,
                                    input logic ic, input logic rt, input logic ho);
    return {1'b0, pg, al, ao, ic, rt, ho};
  endfunction

  task automatic trip();
    oc_i = 1'b1;
    step(CB);
    oc_i = 1'b0;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    step(3);
    check("R1 gate", gate_o, 0);
    check("R1 fault", fault_o, 0);
    check("R1 alert", alert_n_o, 1);
    por_n = 1'b1;
    step(1);

    // R2: all start-condition combinations, on from pin
    wr(2'd0, cw(2'b01, 1, 1, 0, 0, 0));
    for (int c = 0; c < 16; c++) begin
      uv_bad_i = c[0]; ov_bad_i = c[1]; en_i = c[2]; on_i = c[3];
      step(2);
      check("R2 sweep", gate_o, (!c[0] && !c[1] && c[2] && c[3]) ? 1 : 0);
    end
    uv_bad_i = 0; ov_bad_i = 0; en_i = 1; on_i = 1;
    step(2);
    check("R2 pin on", gate_o, 1);
    // R2: host command source
    wr(2'd0, cw(2'b01, 1, 0, 0, 0, 0));
    step(1);
    check("R2 host off", gate_o, 0);
    wr(2'd0, cw(2'b01, 1, 0, 0, 0, 1));
    step(1);
    check("R2 host on", gate_o, 1);

    // R12: status routing
    pg_i = 1; #1;
    check("R12 true pg", stat_o, 1);
    pg_i = 0; #1;
    check("R12 true nopg", stat_o, 0);
    wr(2'd0, cw(2'b10, 1, 1, 1, 1, 0));
    check("R12 inv nopg", stat_o, 1);
    pg_i = 1; #1;
    check("R12 inv pg", stat_o, 0);
    wr(2'd0, cw(2'b00, 1, 1, 1, 1, 0));
    check("R12 none", stat_o, 0);
    check("R2 still on", gate_o, 1);

    // R3: pulses shorter than the window do not trip
    for (int len = 1; len < CB; len++) begin
      oc_i = 1'b1;
      step(len);
      check("R3 short gate", gate_o, 1);
      oc_i = 1'b0;
      step(1);
      check("R3 short fault", fault_o[0], 0);
    end
    // R3/R4: full window trips on the CB-th edge
    oc_i = 1'b1;
    step(CB - 1);
    check("R3 edge before trip", gate_o, 1);
    step(1);
    oc_i = 1'b0;
    check("R4 gate off", gate_o, 0);
    check("R4 oc fault", fault_o[0], 1);
    check("R11 alert", alert_n_o, 0);

    // R7/R8: internal cool-down then auto-retry (tmr_low_i high must be ignored)
    tmr_low_i = 1'b1;
    step(COOL);
    check("R7 still cooling", gate_o, 0);
    step(1);
    check("R8 retry on", gate_o, 1);
    tmr_low_i = 1'b0;

    // R10: sticky, W1C per bit
    wr(2'd1, 8'h02);
    check("R10 sticky", fault_o[0], 1);
    wr(2'd1, 8'h01);
    check("R10 cleared", fault_o[0], 0);
    check("R11 alert released", alert_n_o, 1);

    // R6: external timer cool-down
    wr(2'd0, cw(2'b00, 1, 1, 0, 1, 0));
    trip();
    step(10);
    check("R6 waits timer", gate_o, 0);
    tmr_low_i = 1'b1;
    step(1);
    check("R6 cool ended", gate_o, 0);
    step(1);
    check("R6 retry on", gate_o, 1);
    tmr_low_i = 1'b0;
    wr(2'd1, 8'h03);

    // R9: latch-off, released by fault clear
    wr(2'd0, cw(2'b00, 1, 1, 1, 0, 0));
    trip();
    step(COOL + 5);
    check("R9 latched", gate_o, 0);
    wr(2'd1, 8'h01);
    step(2);
    check("R9 clear releases", gate_o, 1);
    // R9: latch-off, released by on cycling
    trip();
    step(COOL + 5);
    check("R9 latched again", gate_o, 0);
    on_i = 1'b0;
    step(2);
    on_i = 1'b1;
    step(2);
    check("R9 on cycle releases", gate_o, 1);
    check("R9 fault kept", fault_o[0], 1);
    wr(2'd1, 8'h01);

    // R5: supply overvoltage
    vdd_ov_i = 1'b1; #1;
    check("R5 immediate off", gate_o, 0);
    step(1);
    check("R5 ov fault", fault_o[1], 1);
    vdd_ov_i = 1'b0;
    step(1);
    check("R5 back on", gate_o, 1);
    wr(2'd1, 8'h02);
    check("R10 ov cleared", fault_o[1], 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule